// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in, first-out buffer of 64 words of 18 bits. It has a write clock and a read clock. The two clocks may be unrelated, or they may be one shared clock. A word is accepted on a rising write-clock edge when both write qualifiers agree and the buffer reports room. The oldest word then falls through to a registered output, so no read is needed to bring it out. An output-ready flag marks it as present. A read on a rising read-clock edge consumes that word and brings up the next one.

Two fill indicators are produced in the write clock domain. One marks half full. The other marks a fill level near either end of the buffer. The distance from each end is one offset that applies to both ends. The offset is 8 by default. It can be replaced once, from the low data bits, after reset and before the first word is written.

Reset is taken in by each clock domain through its own two-stage synchronizer. Both clocks must therefore run for at least four edges while reset is held low. The read pointer and the write pointer each cross to the other domain as Gray code through two flops. The full and empty decisions this produces are cautious: they may wait a few cycles too long, but a write is never lost and a read never comes from an empty buffer. There are no tri-state pads. In their place, an output-valid qualifier drops whenever either output enable is inactive.

Top module: `xclk_fifo`

## Requirements
- R1: While `rst_n` is held low for four or more edges of each clock, `in_ready`, `out_ready`, `out_valid` and `half_full` are low and `near_limit` is high.
- R2: After `rst_n` rises, `in_ready` is still low after the first rising `wr_clk` edge and is high after the second.
- R3: A word is stored on a rising `wr_clk` edge only when `wr_en`=1, `wr_en_n`=0 and `in_ready`=1. Stored words leave on `dout` in write order, none lost and none repeated.
- R4: The write-side count is words written minus words read. A read becomes visible in it on the third `wr_clk` edge after the read. `in_ready` is low while this count is 64, and a write attempted then is ignored.
- R5: After a word is written into an empty buffer, that word is on `dout` and `out_ready` rises on the third rising `rd_clk` edge after the write edge. It is not on the second.
- R6: A read happens on a rising `rd_clk` edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_ready` is 1. Otherwise `dout` and `out_ready` keep their values, apart from the fall-through load of R5.
- R7: While `out_ready` is low after at least one word has come out, `dout` holds the last word that was read.
- R8: `out_valid` is 1 exactly when `out_ready` is 1 and both `oe_a_n` and `oe_b_n` are 0.
- R9: `half_full` is high when the write-side count of R4 is 32 or more.
- R10: `near_limit` is high when the write-side count is at most K or at least 64−K. K is the offset and is 8 after reset.
- R11: If `prog_n` is 0 on a rising `wr_clk` edge after reset and no word has yet been written, `din[4:0]` becomes K. Once a word has been written, `prog_n` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, synchronized into each domain |
| wr_en | input | 1 | Write qualifier, active high |
| wr_en_n | input | 1 | Write qualifier, active low |
| prog_n | input | 1 | Active-low strobe that loads the flag offset from `din[4:0]` |
| din | input | 18 | Write data |
| in_ready | output | 1 | Room for a word; low means full |
| rd_en_n | input | 1 | Read request, active low |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| dout | output | 18 | Oldest word, registered |
| out_ready | output | 1 | A word is waiting on `dout`; low means empty |
| out_valid | output | 1 | `out_ready` qualified by both output enables |
| half_full | output | 1 | Write-side count is 32 or more |
| near_limit | output | 1 | Write-side count is within K of empty or of full |

## Verification
Suppose a pointer, a synchronizer stage or the held output word goes wrong inside the block. The fault reaches the ports within three or four clock edges. It shows up as a word out of order or repeated on `dout`, or as `out_ready` rising one edge early or late. A skewed write-side count moves the `in_ready`, `half_full` and `near_limit` thresholds on the next write edge. The bench recomputes the pipelined count and the word queue for every cycle. A fault therefore shows as a mismatch in the first cycle where its effect reaches a port.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;
    // Width of the generic Gray conversion helpers; callers truncate.
    localparam int unsigned GW = 32;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/1ps
module xclk_fifo_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = clr_n ? din  : '0;
        s2_d = clr_n ? s1_q : '0;
    end

    always_ff @(posedge clk) begin
        s1_q <= s1_d;
        s2_q <= s2_d;
    end

    assign dout = s2_q;
endmodule

// File: rtl/xclk_fifo_store.sv
`timescale 1ns/1ps
module xclk_fifo_store #(
    parameter  int unsigned DW    = 18,
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // The entry at raddr was written at least three read edges earlier.
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/xclk_fifo_wr.sv
`timescale 1ns/1ps
module xclk_fifo_wr
    import xclk_fifo_pkg::*;
#(
    parameter  int unsigned DEPTH    = 64,
    parameter  int unsigned OFFW     = 5,
    parameter  int unsigned OFF_INIT = 8,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            put,
    input  logic            put_n,
    input  logic            load_n,
    input  logic [OFFW-1:0] load_val,
    input  logic [PW-1:0]   rc_gray_s,
    output logic            live,
    output logic            we,
    output logic [AW-1:0]   waddr,
    output logic [PW-1:0]   wp_gray,
    output logic            in_ready,
    output logic            half_full,
    output logic            near_limit
);
    localparam logic [PW-1:0]   FULL_C  = PW'(DEPTH);
    localparam logic [PW-1:0]   HALF_C  = PW'(DEPTH / 2);
    localparam logic [PW-1:0]   ONE_C   = PW'(1);
    localparam logic [OFFW-1:0] OFF_RST = OFFW'(OFF_INIT);

    typedef struct packed {
        logic            s1;
        logic            s2;
        logic [PW-1:0]   ptr;
        logic [PW-1:0]   gray;
        logic [PW-1:0]   cnt;
        logic [OFFW-1:0] off;
        logic            wrote;
        logic            rdy;
        logic            hf;
        logic            nl;
    } wr_state_t;

    wr_state_t     d, q;
    logic          fire;
    logic [PW-1:0] rc_bin;

    always_comb begin
        rc_bin = PW'(from_gray(GW'(rc_gray_s)));
        fire   = q.rdy & put & ~put_n;
        d      = q;
        d.s1   = rst_n;
        d.s2   = q.s1;
        if (!q.s2) begin
            d.ptr   = '0;
            d.off   = OFF_RST;
            d.wrote = 1'b0;
            d.cnt   = '0;
        end else begin
            if (!load_n && !q.wrote) begin
                d.off = load_val;
            end
            if (fire) begin
                d.ptr   = q.ptr + ONE_C;
                d.wrote = 1'b1;
            end
            d.cnt = d.ptr - rc_bin;
        end
        d.gray = PW'(to_gray(GW'(d.ptr)));
        d.rdy  = q.s1 & (d.cnt < FULL_C);
        d.hf   = (d.cnt >= HALF_C);
        d.nl   = (d.cnt <= PW'(d.off)) | (d.cnt >= (FULL_C - PW'(d.off)));
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign live       = q.s2;
    assign we         = fire;
    assign waddr      = q.ptr[AW-1:0];
    assign wp_gray    = q.gray;
    assign in_ready   = q.rdy;
    assign half_full  = q.hf;
    assign near_limit = q.nl;

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!q.s2)
        q.cnt <= FULL_C);
    a_r11_off_frozen: assert property (@(posedge clk) disable iff (!q.s2)
        q.wrote |=> $stable(q.off));
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!q.s2)
        1'b1 |=> ((q.ptr == $past(q.ptr)) || (q.ptr == $past(q.ptr) + ONE_C)));
    a_r3_wgray_one_bit: assert property (@(posedge clk) disable iff (!q.s2)
        1'b1 |=> $onehot0(q.gray ^ $past(q.gray)));
endmodule

// File: rtl/xclk_fifo_rd.sv
`timescale 1ns/1ps
module xclk_fifo_rd
    import xclk_fifo_pkg::*;
#(
    parameter  int unsigned DW    = 18,
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    input  logic [PW-1:0] wp_gray_s,
    input  logic [DW-1:0] rword,
    output logic          live,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rc_gray,
    output logic [DW-1:0] dout,
    output logic          out_ready,
    output logic          out_valid
);
    localparam logic [PW-1:0] ONE_C = PW'(1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [PW-1:0] fptr;   // words moved into the output register
        logic [PW-1:0] cptr;   // words consumed by reads
        logic [PW-1:0] cgray;
        logic [DW-1:0] word;
        logic          ordy;
    } rd_state_t;

    rd_state_t     d, q;
    logic [PW-1:0] wp_bin;
    logic          oe_on;
    logic          take;
    logic          load;

    always_comb begin
        wp_bin = PW'(from_gray(GW'(wp_gray_s)));
        oe_on  = ~oe_a_n & ~oe_b_n;
        take   = q.ordy & ~take_n & oe_on;
        load   = (q.fptr != wp_bin) & (~q.ordy | take);
        d      = q;
        d.s1   = rst_n;
        d.s2   = q.s1;
        if (!q.s2) begin
            d.fptr = '0;
            d.cptr = '0;
            d.word = '0;
            d.ordy = 1'b0;
        end else begin
            if (take) begin
                d.cptr = q.cptr + ONE_C;
            end
            if (load) begin
                d.word = rword;
                d.fptr = q.fptr + ONE_C;
                d.ordy = 1'b1;
            end else if (take) begin
                d.ordy = 1'b0;
            end
        end
        d.cgray = PW'(to_gray(GW'(d.cptr)));
    end

    always_ff @(posedge clk) begin
        q <= d;
    end

    assign live      = q.s2;
    assign raddr     = q.fptr[AW-1:0];
    assign rc_gray   = q.cgray;
    assign dout      = q.word;
    assign out_ready = q.ordy;
    assign out_valid = q.ordy & oe_on;

    a_r6_no_take_when_empty: assert property (@(posedge clk) disable iff (!q.s2)
        !q.ordy |=> (q.cptr == $past(q.cptr)));
    a_r7_hold_on_drain: assert property (@(posedge clk) disable iff (!q.s2)
        $fell(q.ordy) |-> $stable(q.word));
    a_r6_one_word_ahead: assert property (@(posedge clk) disable iff (!q.s2)
        (q.fptr - q.cptr) <= ONE_C);
    a_r3_rgray_one_bit: assert property (@(posedge clk) disable iff (!q.s2)
        1'b1 |=> $onehot0(q.cgray ^ $past(q.cgray)));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
    parameter  int unsigned DW       = 18,
    parameter  int unsigned DEPTH    = 64,
    parameter  int unsigned OFFW     = 5,
    parameter  int unsigned OFF_INIT = 8,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_en_n,
    input  logic          prog_n,
    input  logic [DW-1:0] din,
    output logic          in_ready,
    input  logic          rd_en_n,
    input  logic          oe_a_n,
    input  logic          oe_b_n,
    output logic [DW-1:0] dout,
    output logic          out_ready,
    output logic          out_valid,
    output logic          half_full,
    output logic          near_limit
);
    logic          wr_live, rd_live, we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wp_gray, wp_gray_s, rc_gray, rc_gray_s;
    logic [DW-1:0] rword;

    xclk_fifo_wr #(.DEPTH(DEPTH), .OFFW(OFFW), .OFF_INIT(OFF_INIT)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .put(wr_en), .put_n(wr_en_n),
        .load_n(prog_n), .load_val(din[OFFW-1:0]), .rc_gray_s(rc_gray_s),
        .live(wr_live), .we(we), .waddr(waddr), .wp_gray(wp_gray),
        .in_ready(in_ready), .half_full(half_full), .near_limit(near_limit)
    );

    xclk_fifo_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .clr_n(rd_live), .din(wp_gray), .dout(wp_gray_s)
    );

    xclk_fifo_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .clr_n(wr_live), .din(rc_gray), .dout(rc_gray_s)
    );

    xclk_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rword)
    );

    xclk_fifo_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .take_n(rd_en_n), .oe_a_n(oe_a_n),
        .oe_b_n(oe_b_n), .wp_gray_s(wp_gray_s), .rword(rword),
        .live(rd_live), .raddr(raddr), .rc_gray(rc_gray), .dout(dout),
        .out_ready(out_ready), .out_valid(out_valid)
    );
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
    localparam int DW    = 18;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz, shared by both domains

    logic          rst_n, wr_en, wr_en_n, prog_n, rd_en_n, oe_a_n, oe_b_n;
    logic [DW-1:0] din, dout;
    logic          in_ready, out_ready, out_valid, half_full, near_limit;

    xclk_fifo u_xclk_fifo (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_en_n(wr_en_n),
        .prog_n(prog_n), .din(din), .in_ready(in_ready), .rd_en_n(rd_en_n),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .dout(dout), .out_ready(out_ready),
        .out_valid(out_valid), .half_full(half_full), .near_limit(near_limit)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Bench model
    logic [DW-1:0] mq[$];
    logic [DW-1:0] e_dout, last_in;
    bit e_rdy, e_ordy, e_hf, e_nl, wrote, seen;
    int e_off, wr_tot, rd_tot, fet_tot;
    int hw[3];
    int hr[3];

    function automatic bit exp_near(int c, int k);
        return (c <= k) || (c >= DEPTH - k);
    endfunction

    function automatic bit exp_half(int c);
        return c >= DEPTH / 2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        bit wf, rf, ld;
        int cnt;
        wf = e_rdy && wr_en && !wr_en_n;
        rf = e_ordy && !rd_en_n && !oe_a_n && !oe_b_n;
        if (!prog_n && !wrote) e_off = int'(din[4:0]);
        if (wf) begin
            wrote = 1'b1;
            mq.push_back(din);
            last_in = din;
            wr_tot++;
        end
        ld = (fet_tot != hw[2]) && (!e_ordy || rf);
        if (rf) rd_tot++;
        if (ld) begin
            e_dout = mq.pop_front();
            fet_tot++;
            e_ordy = 1'b1;
            seen   = 1'b1;
        end else if (rf) begin
            e_ordy = 1'b0;
        end
        cnt   = wr_tot - hr[2];
        e_rdy = cnt < DEPTH;
        e_hf  = exp_half(cnt);
        e_nl  = exp_near(cnt, e_off);
        hw[2] = hw[1]; hw[1] = hw[0]; hw[0] = wr_tot;
        hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = rd_tot;
        @(posedge clk);
        @(negedge clk);
        check("R4", "in_ready", int'(in_ready), int'(e_rdy));
        check("R5", "out_ready", int'(out_ready), int'(e_ordy));
        check("R8", "out_valid", int'(out_valid), int'(e_ordy && !oe_a_n && !oe_b_n));
        check("R9", "half_full", int'(half_full), int'(e_hf));
        check("R10", "near_limit", int'(near_limit), int'(e_nl));
        if (seen) check(e_ordy ? "R3" : "R7", "dout", int'(dout), int'(e_dout));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int unsigned wb, rb;
        void'($urandom(32'd2718));
        rst_n = 1'b0; wr_en = 1'b0; wr_en_n = 1'b1; prog_n = 1'b1;
        rd_en_n = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0; din = '0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R1", "in_ready in reset", int'(in_ready), 0);
        check("R1", "out_ready in reset", int'(out_ready), 0);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "half_full in reset", int'(half_full), 0);
        check("R1", "near_limit in reset", int'(near_limit), 1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2", "in_ready after first edge", int'(in_ready), 0);
        @(posedge clk); @(negedge clk);
        check("R2", "in_ready after second edge", int'(in_ready), 1);

        e_rdy = 1'b1; e_ordy = 1'b0; e_hf = 1'b0; e_nl = 1'b1; e_off = 8;
        wrote = 1'b0; seen = 1'b0; wr_tot = 0; rd_tot = 0; fet_tot = 0;
        e_dout = '0; last_in = '0;
        for (int i = 0; i < 3; i++) begin hw[i] = 0; hr[i] = 0; end

        // R11: load offset 5 before any write
        prog_n = 1'b0; din = 18'd5; step(); prog_n = 1'b1;

        // R5: first-word fall-through timing
        wr_en = 1'b1; wr_en_n = 1'b0; din = 18'h2A5A5; step(); wr_en = 1'b0;
        step(); step();
        check("R5", "out_ready two edges after write", int'(out_ready), 0);
        step();
        check("R5", "out_ready three edges after write", int'(out_ready), 1);
        check("R5", "first word on dout", int'(dout), int'(18'h2A5A5));

        // R11: reprogramming after a write is ignored
        prog_n = 1'b0; din = 18'd20; step(); prog_n = 1'b1;

        // R4, R9, R10: fill past full with reads blocked
        wr_en = 1'b1;
        for (int i = 0; i < 70; i++) begin
            din = DW'($urandom);
            step();
            if (wr_tot == 50) check("R11", "near_limit at 50 words", int'(near_limit), 0);
        end
        wr_en = 1'b0;
        check("R4", "in_ready when full", int'(in_ready), 0);
        check("R4", "words accepted", wr_tot, DEPTH);

        // R6: reads blocked by each disable
        rd_en_n = 1'b0; oe_a_n = 1'b1;
        repeat (3) step();
        check("R6", "dout with oe_a_n high", int'(dout), int'(18'h2A5A5));
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        repeat (3) step();
        check("R6", "dout with oe_b_n high", int'(dout), int'(18'h2A5A5));
        oe_b_n = 1'b0; rd_en_n = 1'b1;
        repeat (2) step();
        check("R6", "dout with rd_en_n high", int'(dout), int'(18'h2A5A5));

        // R7: drain completely
        rd_en_n = 1'b0;
        repeat (80) step();
        check("R7", "out_ready after drain", int'(out_ready), 0);
        check("R7", "dout holds last word", int'(dout), int'(last_in));

        // Random phases alternating fill bias and drain bias
        for (int ph = 0; ph < 8; ph++) begin
            wb = (ph % 2 == 0) ? 32'd80 : 32'd20;
            rb = (ph % 2 == 0) ? 32'd30 : 32'd85;
            for (int n = 0; n < 500; n++) begin
                wr_en   = ($urandom % 100) < wb;
                wr_en_n = ($urandom % 10) == 0;
                rd_en_n = ($urandom % 100) >= rb;
                oe_a_n  = ($urandom % 16) == 0;
                oe_b_n  = ($urandom % 16) == 0;
                prog_n  = ($urandom % 2) == 0;
                din     = DW'($urandom);
                step();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule